// File: doc/BRIEF.md
# Daisy-Chained Bus Request Node

This block is the bus-request front end for one bus master, such as a DMA engine, that shares a single active-low, wired-AND request line with other masters. The node pulls that line low through an open-drain enable, and it reads the resolved line back. A grant reaches the node through a serial acknowledge chain. The node either passes the incoming acknowledge on to the next node, or it keeps that acknowledge for itself when it is requesting or owns the bus.

A node may only begin a request on a clock edge where it sees the shared line high, that is, where no other master is requesting. Several nodes that begin on the same edge are sorted by their position in the chain. The node nearest the acknowledge source wins, and the losers keep holding the line low until they are granted. An owner keeps the bus until its master signals done. No node can take the bus away from it.

All pins are plain level controls. No data moves through the block, so there is no valid/ready handshake. The master holds `mst_req` high while it wants the bus and pulses `mst_done` for one cycle when its transfer is finished.

Top module: `bus_req_node`

## Requirements
- R1: While `rst_n` is low, `line_pull` and `bus_owner` are 0 and `ack_out` is 0 whatever the value of `ack_in`.
- R2: While the node is idle, `ack_out` equals `ack_in` in the same cycle (default `ACK_REG`=0).
- R3: When the node is idle and, at a clock edge, `mst_req`=1 and `bus_line_n`=1, then `line_pull` is 1 from the next cycle.
- R4: When the node is idle and `bus_line_n`=0 at an edge, `line_pull` stays 0 after that edge, whatever `mst_req` is.
- R5: While `line_pull`=1, `ack_out` is 0, including the cycle in which `ack_in` rises.
- R6: When the node is requesting and `ack_in`=1 at an edge, `bus_owner` is 1 from the next cycle and `line_pull` stays 1.
- R7: When the node is requesting, `mst_req`=1 and `ack_in`=0, it keeps `line_pull`=1 indefinitely, without regard to `bus_line_n`.
- R8: An owner stays owner, with `line_pull`=1, until `mst_done`. Changes on `mst_req` and `bus_line_n` do not remove it.
- R9: When the owner sees `mst_done`=1 at an edge, `line_pull` and `bus_owner` are 0 from the next cycle, and `ack_out` stays 0 while `ack_in` remains 1.
- R10: After a release, the node returns to idle on the first edge where `ack_in`=0. After that, pass-through (R2) resumes.
- R11: When the node is requesting and, at an edge, `mst_req`=0 and `ack_in`=0, the request is withdrawn: `line_pull` is 0 from the next cycle.
- R12: `mst_done` has no effect unless the node is owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_req | input | 1 | Master wants the bus (level) |
| mst_done | input | 1 | Master finished its transfer (one-cycle pulse) |
| bus_line_n | input | 1 | Resolved shared request line, low when any node requests |
| line_pull | output | 1 | Open-drain enable: 1 pulls the shared line low |
| ack_in | input | 1 | Acknowledge from the upstream (higher-priority) side |
| ack_out | output | 1 | Acknowledge passed to the downstream node |
| bus_owner | output | 1 | The master owns the bus |

## Verification
Two events can land on the same edge. First, the master raises its request on the very edge where another master starts pulling the shared line low. Second, the upstream acknowledge arrives in the same cycle the node is still requesting. The bench provokes the first by raising the other master's pull and `mst_req` together, and expects no request from this node. It provokes the second by raising `ack_in` during a pending request, and checks that `ack_out` stays 0 in that very cycle while ownership follows on the next edge. A behavioural model predicts every output on every cycle, and the chain priority is reproduced by withholding `ack_in` while another master holds the line.

// File: rtl/brn_pkg.sv
package brn_pkg;
  typedef enum logic [1:0] {
    BRN_IDLE = 2'd0,
    BRN_REQ  = 2'd1,
    BRN_OWN  = 2'd2,
    BRN_REL  = 2'd3
  } brn_state_e;
endpackage

// File: rtl/brn_state_ctl.sv
module brn_state_ctl
  import brn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mst_req,
  input  logic       mst_done,
  input  logic       line_hi,
  input  logic       ack_in,
  output brn_state_e state,
  output logic       idle_next
);
  brn_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      BRN_IDLE: if (mst_req && line_hi) state_d = BRN_REQ;
      BRN_REQ: begin
        if (ack_in)        state_d = BRN_OWN;
        else if (!mst_req) state_d = BRN_IDLE;
      end
      BRN_OWN:  if (mst_done) state_d = BRN_REL;
      BRN_REL:  if (!ack_in)  state_d = BRN_IDLE;
      default:  state_d = BRN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= BRN_IDLE;
    else        state <= state_d;
  end

  assign idle_next = (state_d == BRN_IDLE);

  // R6: a pending request meeting the acknowledge becomes ownership
  a_r6_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BRN_REQ && ack_in) |=> (state == BRN_OWN));
  // R4: a busy line never lets an idle node start
  a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BRN_IDLE && !line_hi) |=> (state == BRN_IDLE));
  // R12: done outside ownership changes nothing
  a_r12_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BRN_REL && mst_done && ack_in) |=> (state == BRN_REL));
endmodule

// File: rtl/brn_ack_relay.sv
module brn_ack_relay
  import brn_pkg::*;
#(
  parameter bit ACK_REG = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_in,
  input  brn_state_e state,
  input  logic       idle_next,
  output logic       ack_out
);
  generate
    if (ACK_REG) begin : g_reg
      logic ack_q;
      always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= idle_next && ack_in;
      end
      assign ack_out = ack_q;
    end else begin : g_comb
      assign ack_out = rst_n && (state == BRN_IDLE) && ack_in;
    end
  endgenerate

  // R5: no acknowledge leaks downstream while this node claims the bus
  a_r5_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != BRN_IDLE) |-> !ack_out);
endmodule

// File: rtl/bus_req_node.sv
module bus_req_node
  import brn_pkg::*;
#(
  parameter bit ACK_REG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mst_req,
  input  logic mst_done,
  input  logic bus_line_n,
  output logic line_pull,
  input  logic ack_in,
  output logic ack_out,
  output logic bus_owner
);
  brn_state_e state;
  logic       idle_next;

  brn_state_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mst_req   (mst_req),
    .mst_done  (mst_done),
    .line_hi   (bus_line_n),
    .ack_in    (ack_in),
    .state     (state),
    .idle_next (idle_next)
  );

  brn_ack_relay #(.ACK_REG(ACK_REG)) u_relay (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_in    (ack_in),
    .state     (state),
    .idle_next (idle_next),
    .ack_out   (ack_out)
  );

  assign line_pull = (state == BRN_REQ) || (state == BRN_OWN);
  assign bus_owner = (state == BRN_OWN);

  // R1: reset leaves the line and the chain quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!line_pull && !bus_owner));
  // R8: ownership persists until done
  a_r8_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owner && !mst_done) |=> (bus_owner && line_pull));
  // R9: done drops the pull and ownership together
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_owner && mst_done) |=> (!bus_owner && !line_pull));
  // R7: a waiting node keeps pulling
  a_r7_keep_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pull && !bus_owner && mst_req && !ack_in) |=> line_pull);
endmodule

// File: tb/bus_req_node_tb.sv
module bus_req_node_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mst_req = 1'b0, mst_done = 1'b0, ack_in = 1'b0, other_pull = 1'b0;
  logic line_pull, ack_out, bus_owner, bus_line_n;
  int   n_run = 0, n_fail = 0, wd = 0;
  int   ms = 0; // 0 idle, 1 requesting, 2 owner, 3 release

  always #(CLK_PERIOD/2) clk = ~clk;
  assign bus_line_n = ~(line_pull | other_pull);

  bus_req_node u_dut (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_done(mst_done),
    .bus_line_n(bus_line_n), .line_pull(line_pull), .ack_in(ack_in),
    .ack_out(ack_out), .bus_owner(bus_owner)
  );

  always @(posedge clk) begin
    if (!rst_n) ms <= 0;
    else case (ms)
      0: if (mst_req && bus_line_n) ms <= 1;
      1: if (ack_in) ms <= 2; else if (!mst_req) ms <= 0;
      2: if (mst_done) ms <= 3;
      3: if (!ack_in) ms <= 0;
      default: ms <= 0;
    endcase
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic r, input logic d, input logic a, input logic o);
    @(negedge clk);
    mst_req = r; mst_done = d; ack_in = a; other_pull = o;
    #1;
    chk("R3 model pull", line_pull, (ms == 1 || ms == 2));
    chk("R6 model owner", bus_owner, (ms == 2));
    chk("R2 model ack_out", ack_out, (rst_n && ms == 0 && ack_in));
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    ack_in = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset pull", line_pull, 1'b0);
    chk("R1 reset owner", bus_owner, 1'b0);
    chk("R1 reset ack_out", ack_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    // R2 pass-through in idle
    cyc(0,0,1,0); chk("R2 pass high", ack_out, 1'b1);
    cyc(0,0,0,0); chk("R2 pass low", ack_out, 1'b0);
    cyc(0,0,1,0); chk("R2 pass high again", ack_out, 1'b1);
    // R4 same-edge collision: other master pulls as req rises
    cyc(1,0,0,1);
    cyc(1,0,0,1); chk("R4 blocked", line_pull, 1'b0);
    cyc(1,0,0,1); chk("R4 still blocked", line_pull, 1'b0);
    // R3 line frees, request starts on next edge
    cyc(1,0,0,0);
    cyc(1,0,0,1); chk("R3 started", line_pull, 1'b1);
    // R7 lost contest: keep pulling while other holds
    for (int i = 0; i < 4; i++) cyc(1,0,0,1);
    chk("R7 holding", line_pull, 1'b1);
    // R5 ack arrives while requesting
    cyc(1,0,1,0); chk("R5 ack blocked", ack_out, 1'b0);
    cyc(1,0,1,0); chk("R6 granted", bus_owner, 1'b1);
    // R8 owner ignores req and line changes, done in wrong state none
    cyc(0,0,1,1); cyc(0,0,1,0); cyc(1,0,1,1);
    chk("R8 still owner", bus_owner, 1'b1);
    chk("R8 still pulling", line_pull, 1'b1);
    // R9 done
    cyc(0,1,1,0);
    cyc(0,0,1,0);
    chk("R9 pull off", line_pull, 1'b0);
    chk("R9 owner off", bus_owner, 1'b0);
    chk("R9 ack held", ack_out, 1'b0);
    // R12 done while releasing has no effect
    cyc(0,1,1,0); cyc(0,0,1,0);
    chk("R12 release unchanged", ack_out, 1'b0);
    // R10 ack drops, back to idle
    cyc(0,0,0,0); cyc(0,0,1,0);
    chk("R10 pass resumed", ack_out, 1'b1);
    // R12 done in idle
    cyc(0,1,0,0); cyc(0,0,0,0);
    chk("R12 idle pull", line_pull, 1'b0);
    chk("R12 idle owner", bus_owner, 1'b0);
    // R11 withdraw
    cyc(1,0,0,0); cyc(0,0,0,0);
    chk("R11 requesting", line_pull, 1'b1);
    cyc(0,0,0,0);
    chk("R11 withdrawn", line_pull, 1'b0);
    // second full round trip
    cyc(1,0,0,0); cyc(1,0,1,0); cyc(1,0,1,0);
    chk("R6 second grant", bus_owner, 1'b1);
    cyc(1,1,1,0); cyc(0,0,0,0); cyc(0,0,1,0);
    chk("R10 second return", ack_out, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule